// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives a card clock from a fast input clock. The card clock runs at the input rate, at half of it, or at a quarter of it. A small control word selects the ratio. It is captured into a holding register when a load strobe is present. The new ratio does not reach the output at once. It waits until the divider chain reaches its alignment point, which is the rising edge of the slowest divider stage. The switch therefore never produces a pulse shorter than the faster of the two ratios involved.

The divided outputs are bits of a free-running binary counter, so each divided ratio has an exact 50% duty cycle. At the undivided ratio the output is the input clock gated by the selection, so its duty cycle is only as good as the input's. Software that writes a new ratio must allow up to four input cycles before the card sees it. The number of divider stages is a parameter. The default of two stages gives the three ratios.

Top module: `cardclk_divider`

## Requirements
- R1: Ratio codes with the default two stages: 00 selects 1:1, 01 selects 1:2, 10 selects 1:4, and 11 is treated as 1:4.
- R2: At 1:2 the output is high for one input period and low for one. At 1:4 it is high for two input periods and low for two. All level changes follow a rising input edge.
- R3: At 1:1 the output equals the input clock.
- R4: The active ratio changes only at the rising input edge on which the divide-by-4 stage rises, which happens once every four input cycles. Until that edge the output keeps the old ratio.
- R5: The ratio input is captured into the holding register only on a rising edge at which the load strobe is high. Changes of the ratio input without the strobe have no effect on the output.
- R6: Suppose a load coincides with an alignment edge. The active ratio then takes the holding value from before that edge, and the newly loaded ratio takes effect at the next alignment edge.
- R7: No high or low output pulse is shorter than the half-period of the fastest ratio that was active during that pulse.
- R8: Reset is synchronous and active high. While it is asserted the output is low. On the edge it is seen, the counter clears and both the holding and active ratios return to 1:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock; also the source of the 1:1 output |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | SEL_W (2) | Requested division code |
| ratio_load | input | 1 | Captures ratio_sel into the holding register on a rising edge |
| card_clk | output | 1 | Divided card clock |

## Verification
The bench builds the block with the default of two stages. With that setting all three ratios are reachable, as is the clamped code 11. The four-phase counter also makes every position of a load relative to the alignment edge reachable. The output is sampled in both halves of every input period and compared against an independent model of the requirements. Every finished pulse is measured against the half-period of the fastest ratio active during it. Stimulus includes a table of steady ratios, a few hundred random switches, a load landing exactly on an alignment edge, ratio changes without a strobe, and a reset in mid-run.

// File: rtl/cardclk_pkg.sv
`timescale 1ns/1ps
package cardclk_pkg;

  // Map a requested code onto a divider stage index; codes past the last
  // stage fall back to the slowest ratio.
  function automatic int unsigned code_to_stage(input int unsigned code,
                                                input int unsigned stages);
    return (code > stages) ? stages : code;
  endfunction

endpackage

// File: rtl/ccd_counter.sv
`timescale 1ns/1ps
module ccd_counter #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [STAGES-1:0] cnt_q,
  output logic              align_o
);

  // Counter value one edge before the top stage rises (0111..1).
  localparam logic [STAGES-1:0] PRE_TOP = STAGES'((1 << (STAGES-1)) - 1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  // High during the cycle whose closing edge raises the slowest stage.
  assign align_o = (cnt_q == PRE_TOP);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_q == $past(cnt_q) + 1'b1);

  a_r8_count_clear: assert property (@(posedge clk)
    $past(rst) |-> cnt_q == '0);

endmodule

// File: rtl/ccd_ratio_ctrl.sv
`timescale 1ns/1ps
module ccd_ratio_ctrl
  import cardclk_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             align_i,
  output logic [SEL_W-1:0] act_q
);

  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(STAGES);

  logic [SEL_W-1:0] hold_q;
  logic [SEL_W-1:0] sel_clamped;

  assign sel_clamped = SEL_W'(code_to_stage(int'(sel_i), STAGES));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (load_i)  hold_q <= sel_clamped;
      if (align_i) act_q  <= hold_q;
    end
  end

  a_r4_act_only_at_align: assert property (@(posedge clk) disable iff (rst)
    !$past(align_i) |-> $stable(act_q));

  a_r6_act_takes_old_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(align_i) && !$past(rst)) |-> act_q == $past(hold_q));

  a_r5_load_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(load_i) && !$past(rst) && $past(sel_i) <= TOP_CODE)
      |-> hold_q == $past(sel_i));

  a_r8_ratio_clear: assert property (@(posedge clk)
    $past(rst) |-> (act_q == '0 && hold_q == '0));

endmodule

// File: rtl/ccd_out_mux.sv
`timescale 1ns/1ps
module ccd_out_mux #(
  parameter int STAGES = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAGES-1:0] cnt_i,
  input  logic [SEL_W-1:0]  act_i,
  output logic              card_clk
);

  // Tap 0 is the input clock; tap k is divider stage k-1 (ratio 1:2^k).
  logic [STAGES:0] taps;

  assign taps[0] = clk;
  for (genvar k = 1; k <= STAGES; k++) begin : g_tap
    assign taps[k] = cnt_i[k-1];
  end

  assign card_clk = rst ? 1'b0 : taps[act_i];

endmodule

// File: rtl/cardclk_divider.sv
`timescale 1ns/1ps
module cardclk_divider #(
  parameter  int STAGES = 2,
  localparam int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             ratio_load,
  output logic             card_clk
);

  logic [STAGES-1:0] cnt;
  logic              align;
  logic [SEL_W-1:0]  act;

  ccd_counter #(.STAGES(STAGES)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt_q   (cnt),
    .align_o (align)
  );

  ccd_ratio_ctrl #(.STAGES(STAGES), .SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ratio_load),
    .sel_i   (ratio_sel),
    .align_i (align),
    .act_q   (act)
  );

  ccd_out_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnt),
    .act_i    (act),
    .card_clk (card_clk)
  );

endmodule

// File: tb/sim_cardclk_divider.sv
`timescale 1ns/1ps
module sim_cardclk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       ld  = 1'b0;
  logic       card_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase_tag = "";

  always #4 clk = ~clk;  // 125 MHz

  cardclk_divider u0 (
    .clk(clk), .rst(rst), .ratio_sel(sel), .ratio_load(ld), .card_clk(card_clk)
  );

  // Independent model built from the requirements.
  logic [1:0] m_cnt = 2'd0, m_hold = 2'd0, m_act = 2'd0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_cnt <= 2'd0; m_hold <= 2'd0; m_act <= 2'd0;
    end else begin
      m_cnt <= m_cnt + 2'd1;
      if (ld) m_hold <= sel;
      if (m_cnt == 2'd1) m_act <= m_hold;  // divide-by-4 stage rises next
    end
  end

  function automatic logic exp_out(input logic r, input logic [1:0] a,
                                   input logic [1:0] c, input logic ph);
    if (r) return 1'b0;
    case (a)
      2'd0: return ph;
      2'd1: return c[0];
      default: return c[1];
    endcase
  endfunction

  function automatic int half_of(input logic [1:0] a);
    return (a == 2'd0) ? 1 : (a == 2'd1) ? 2 : 4;
  endfunction

  // Pulse tracker, in half-period units.
  logic lvl = 1'b0;
  bit   run_valid = 0;
  int   run_len = 0, run_min = 0, last_high = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic sample(input logic ph);
    logic  e;
    string tag;
    e = exp_out(rst, m_act, m_cnt, ph);
    if (phase_tag != "")   tag = phase_tag;
    else if (rst)          tag = "R8";
    else if (m_act != m_hold) tag = "R4";
    else if (m_act == 2'd3) tag = "R1";
    else if (m_act == 2'd0) tag = "R3";
    else                   tag = "R2";
    check(card_clk === e, tag, card_clk, e);
    if (rst) begin
      run_valid = 0; lvl = 1'b0; run_len = 0;
    end else if (card_clk !== lvl) begin
      if (run_valid) check(run_len >= run_min, "R7 pulse width", run_len, run_min);
      if (lvl) last_high = run_len;
      run_valid = 1; lvl = card_clk; run_len = 1; run_min = half_of(m_act);
    end else begin
      run_len++;
      if (half_of(m_act) < run_min) run_min = half_of(m_act);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #2; sample(1'b1);
      @(negedge clk); #2; sample(1'b0);
    end
  end

  task automatic cyc(input logic r, input logic [1:0] s, input logic l);
    @(negedge clk); #1;
    rst = r; sel = s; ld = l;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    check(1'b0, "watchdog", cycles, 100000);
    finish_run();
  end

  // {code, hold cycles, expected steady high run in half-periods}
  localparam logic [13:0] VEC [8] = '{
    {2'b01, 8'd12, 4'd2}, {2'b10, 8'd14, 4'd4}, {2'b00, 8'd12, 4'd1},
    {2'b11, 8'd14, 4'd4}, {2'b01, 8'd12, 4'd2}, {2'b00, 8'd10, 4'd1},
    {2'b10, 8'd14, 4'd4}, {2'b01, 8'd12, 4'd2}
  };

  initial begin
    // R8: reset state
    repeat (3) cyc(1'b1, 2'b10, 1'b1);
    check(card_clk === 1'b0, "R8 output low in reset", card_clk, 0);
    cyc(1'b0, 2'b00, 1'b0);
    repeat (4) cyc(1'b0, 2'b00, 1'b0);

    // Table walk: steady ratios, high-run length per code (R1, R2, R3)
    foreach (VEC[i]) begin
      cyc(1'b0, VEC[i][13:12], 1'b1);
      repeat (int'(VEC[i][11:4])) cyc(1'b0, VEC[i][13:12], 1'b0);
      check(last_high == int'(VEC[i][3:0]),
            (VEC[i][13:12] == 2'b00) ? "R3 high run" :
            (VEC[i][13:12] == 2'b11) ? "R1 code 11 high run" : "R2 high run",
            last_high, VEC[i][3:0]);
    end

    // R5: code changes without a strobe are ignored
    phase_tag = "R5";
    cyc(1'b0, 2'b01, 1'b1);
    repeat (10) cyc(1'b0, 2'b01, 1'b0);
    for (int k = 0; k < 16; k++) cyc(1'b0, 2'(k), 1'b0);
    repeat (6) cyc(1'b0, 2'b00, 1'b0);
    check(last_high == 2, "R5 ratio unchanged", last_high, 2);

    // R6: load lands on the alignment edge
    phase_tag = "R6";
    cyc(1'b0, 2'b00, 1'b1);
    repeat (10) cyc(1'b0, 2'b00, 1'b0);
    while (m_cnt != 2'd1) @(negedge clk);
    #1; sel = 2'b10; ld = 1'b1;
    cyc(1'b0, 2'b10, 1'b0);
    #1;
    check(m_act == 2'd0, "R6 old ratio kept (model)", m_act, 0);
    repeat (12) cyc(1'b0, 2'b10, 1'b0);
    check(last_high == 4, "R6 new ratio later", last_high, 4);
    phase_tag = "";

    // Random switching, checked sample by sample and pulse by pulse (R4, R7)
    for (int n = 0; n < 300; n++) begin
      logic [1:0] s;
      s = 2'($urandom_range(0, 3));
      cyc(1'b0, s, 1'b1);
      repeat ($urandom_range(0, 8)) cyc(1'b0, s, 1'b0);
    end

    // R8: reset in mid-run
    cyc(1'b1, 2'b00, 1'b0);
    check(card_clk === 1'b0, "R8 mid-run reset low", card_clk, 0);
    cyc(1'b1, 2'b00, 1'b0);
    cyc(1'b0, 2'b00, 1'b0);
    repeat (8) cyc(1'b0, 2'b00, 1'b0);
    check(last_high == 1, "R8 ratio back to 1:1", last_high, 1);

    finish_run();
  end

endmodule